// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in self-test of a dot-matrix character display controller. A control-word write that sets the self-test bit (bit 6 of the control word) starts the test. The block then owns the display for a fixed number of clock periods.

In the first half of the run, two things happen at once. The block reads every row of every glyph in the font ROM and adds up the five column bits of each row into an 8-bit checksum. It also drives a checkerboard override onto the scanner. In the second half it drives the inverted checkerboard. When the ROM scan finishes, the block compares the checksum with a stored constant and latches a pass flag. Software reads this flag as a read-only bit of the control word.

After the timed pattern phases, the block pulses a one-cycle strobe that tells the register file to load its post-test values:
- every character cell is set to the blank code;
- the flash mask is cleared;
- the control word is cleared except for the result bit;
- the custom-glyph address register is filled with ones.

Top module: `dsp_selftest_seq`

## Requirements
- R1: After reset, `busy`, `pass`, `pat_en`, `pat_inv`, `rom_en` and `init_stb` are all 0.
- R2: When idle, a cycle with `ctl_we`=1 and `ctl_run`=1 starts a test: `busy` is 1 from the next cycle. A write with `ctl_run`=0 starts nothing.
- R3: `rom_en` is 1 for exactly NUM_CHARS*ROWS cycles, starting in the first busy cycle. In scan cycle k, `rom_addr` = {k/ROWS, k%ROWS}: glyph code in the upper 7 bits, row in the lower 3 bits. The row advances fastest.
- R4: At the end of the scan, `pass` becomes 1 if the 8-bit modular sum of all sampled `rom_data` values equals EXP_SUM, and 0 otherwise.
- R5: `pat_en` is 1 for exactly TEST_CYC cycles. `pat_inv` is 0 for the first TEST_CYC/2 of those cycles and 1 for the rest.
- R6: `busy` stays 1 for exactly TEST_CYC+1 cycles. This is the pattern time plus the initialization cycle.
- R7: `init_stb` is 1 for exactly one cycle, the one after the last pattern cycle. In that cycle:
  - `init_chr` = 0x20;
  - `init_udc` = 4'hF;
  - `init_ctl` has bit 5 equal to `pass` and every other bit 0.
- R8: Start writes made while `busy` is 1 are ignored: the run length does not change.
- R9: `pass` changes only when a scan ends. Control writes with `ctl_run`=0 leave it unchanged, and it keeps the previous result until the next scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_run | input | 1 | Self-test bit (bit 6) of the written control word |
| rom_en | output | 1 | Font ROM read in this cycle |
| rom_addr | output | 10 | Font ROM address {glyph[6:0], row[2:0]} |
| rom_data | input | 5 | Column bits of the addressed row, valid in the same cycle |
| pat_en | output | 1 | Checkerboard override to the scanner |
| pat_inv | output | 1 | Selects the inverted checkerboard |
| busy | output | 1 | Test in progress |
| pass | output | 1 | Self-test result (control word bit 5) |
| init_stb | output | 1 | Load post-test values into the register file |
| init_ctl | output | 8 | Control word value to load |
| init_chr | output | 8 | Character code to load into every cell |
| init_udc | output | 4 | Custom-glyph address register value to load |

## Verification
The assertions assume that `rom_data` is a pure function of `rom_addr` in the same cycle. They also assume that TEST_CYC/2 is at least NUM_CHARS*ROWS, so that the scan ends inside the plain-checkerboard half.

The bench models the ROM as an arithmetic function of glyph and row, and sets TEST_CYC to 4096. It compares every cycle of each run against the expected schedule. It also injects a start write in the middle of a run and a single corrupted ROM row in one run. Apart from that deliberate mid-run write, the stimulus makes no host access while `busy` is 1.

// File: rtl/dsp_selftest_seq.sv
module dsp_selftest_seq #(
  parameter int TEST_CYC = 262144,
  parameter int NUM_CHARS = 128,
  parameter int ROWS = 7,
  parameter int COL_W = 5,
  parameter int SUM_W = 8,
  parameter logic [SUM_W-1:0] EXP_SUM = '0,
  parameter int RES_BIT = 5,
  parameter logic [7:0] BLANK = 8'h20,
  parameter int UDC_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_run,
  output logic rom_en,
  output logic [$clog2(NUM_CHARS)+$clog2(ROWS)-1:0] rom_addr,
  input  logic [COL_W-1:0] rom_data,
  output logic pat_en,
  output logic pat_inv,
  output logic busy,
  output logic pass,
  output logic init_stb,
  output logic [7:0] init_ctl,
  output logic [7:0] init_chr,
  output logic [UDC_W-1:0] init_udc
);
  localparam int CH_W = $clog2(NUM_CHARS);
  localparam int RW_W = $clog2(ROWS);
  localparam int CNT_W = $clog2(TEST_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TEST_CYC - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(TEST_CYC / 2);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_INIT} st_t;
  st_t st;

  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  ch;
  logic [RW_W-1:0]  row;
  logic [SUM_W-1:0] sum;
  logic             scan;

  wire last_row = (row == RW_W'(ROWS - 1));
  wire last_ch  = (ch == CH_W'(NUM_CHARS - 1));
  wire [SUM_W-1:0] sum_nx = sum + SUM_W'(rom_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ch <= '0;
      row <= '0;
      sum <= '0;
      scan <= 1'b0;
      pass <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (ctl_we && ctl_run) begin
          st <= S_RUN;
          cnt <= '0;
          ch <= '0;
          row <= '0;
          sum <= '0;
          scan <= 1'b1;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_INIT;
          if (scan) begin
            sum <= sum_nx;
            if (last_row) begin
              row <= '0;
              ch <= ch + 1'b1;
              if (last_ch) begin
                scan <= 1'b0;
                pass <= (sum_nx == EXP_SUM);
              end
            end else begin
              row <= row + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign pat_en   = (st == S_RUN);
  assign pat_inv  = pat_en && (cnt >= HALF);
  assign rom_en   = pat_en && scan;
  assign rom_addr = {ch, row};
  assign init_stb = (st == S_INIT);
  assign init_chr = BLANK;
  assign init_udc = '1;

  always_comb begin
    init_ctl = '0;
    init_ctl[RES_BIT] = pass;
  end
endmodule

// File: rtl/dsp_selftest_chk.sv
module dsp_selftest_chk (
  input logic clk,
  input logic rst_n,
  input logic rom_en,
  input logic pat_en,
  input logic pat_inv,
  input logic busy,
  input logic pass,
  input logic init_stb
);
  AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |=> !init_stb); // R7
  AST_INIT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |=> !busy); // R6
  AST_PAT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    pat_en |-> busy); // R5
  AST_INV_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && pat_inv) |=> (!pat_en || pat_inv)); // R5
  AST_SCAN_IN_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (pat_en && !pat_inv)); // R3
  AST_PASS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(pass)); // R9
  AST_PATTERN_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_stb) |-> $past(pat_en && pat_inv)); // R7
endmodule

bind dsp_selftest_seq dsp_selftest_chk u_chk (.*);

// File: tb/tb_dsp_selftest_seq.sv
module tb_dsp_selftest_seq;
  localparam int TEST_CYC = 4096;
  localparam int NCH = 128;
  localparam int NR = 7;
  localparam int STEPS = NCH * NR;

  function automatic logic [4:0] glyph_row(input int c, input int r);
    return 5'((c * 3 + r * 11 + 2) % 32);
  endfunction

  function automatic logic [7:0] gold_sum();
    logic [7:0] s = '0;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NR; r++) s = s + 8'(glyph_row(c, r));
    return s;
  endfunction

  localparam logic [7:0] GOLD = gold_sum();

  logic clk = 0, rst_n = 0, ctl_we = 0, ctl_run = 0, corrupt = 0;
  logic rom_en, pat_en, pat_inv, busy, pass, init_stb;
  logic [9:0] rom_addr;
  logic [4:0] rom_data;
  logic [7:0] init_ctl, init_chr;
  logic [3:0] init_udc;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  always_comb begin
    rom_data = glyph_row(int'(rom_addr[9:3]), int'(rom_addr[2:0]));
    if (corrupt && rom_addr == 10'h155) rom_data = rom_data ^ 5'h01;
  end

  dsp_selftest_seq #(.TEST_CYC(TEST_CYC), .EXP_SUM(GOLD)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data),
    .pat_en(pat_en), .pat_inv(pat_inv), .busy(busy), .pass(pass),
    .init_stb(init_stb), .init_ctl(init_ctl), .init_chr(init_chr),
    .init_udc(init_udc));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic run_test(input bit exp_pass, input bit prev_pass, input bit mid_start);
    int e_scan = 0, e_pat = 0, e_busy = 0;
    @(negedge clk); ctl_we = 1; ctl_run = 1;
    @(negedge clk); ctl_we = 0; ctl_run = 0;
    check("R2 busy after start", busy, 1);
    check("R9 previous result kept", pass, prev_pass);
    for (int k = 0; k < TEST_CYC; k++) begin
      if (!busy) e_busy++;
      if (!pat_en || pat_inv != (k >= TEST_CYC / 2)) e_pat++;
      if (rom_en != (k < STEPS)) e_scan++;
      else if (k < STEPS && rom_addr != {7'(k / NR), 3'(k % NR)}) e_scan++;
      if (init_stb) e_busy++;
      if (mid_start && k == 100) begin ctl_we = 1; ctl_run = 1; end
      if (mid_start && k == 101) begin ctl_we = 0; ctl_run = 0; end
      @(negedge clk);
    end
    check("R3 scan schedule errors", e_scan, 0);
    check("R5 pattern schedule errors", e_pat, 0);
    check("R6 R8 busy during run errors", e_busy, 0);
    check("R7 init strobe", init_stb, 1);
    check("R6 busy in init", busy, 1);
    check("R5 pattern off in init", pat_en, 0);
    check("R4 pass", pass, exp_pass);
    check("R7 init_ctl", init_ctl, exp_pass ? 8'h20 : 8'h00);
    check("R7 init_chr", init_chr, 8'h20);
    check("R7 init_udc", init_udc, 4'hF);
    @(negedge clk);
    check("R6 busy drops", busy, 0);
    check("R7 strobe single", init_stb, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 pass", pass, 0);
    check("R1 pat_en", pat_en, 0);
    check("R1 pat_inv", pat_inv, 0);
    check("R1 rom_en", rom_en, 0);
    check("R1 init_stb", init_stb, 0);
    ctl_we = 1; ctl_run = 0;
    @(negedge clk); ctl_we = 0;
    @(negedge clk);
    check("R2 no start without run bit", busy, 0);
    run_test(1, 0, 1);
    corrupt = 1;
    run_test(0, 1, 0);
    corrupt = 0;
    ctl_we = 1; ctl_run = 0;
    repeat (3) @(negedge clk);
    ctl_we = 0;
    @(negedge clk);
    check("R9 pass unchanged by plain write", pass, 0);
    check("R2 plain write stays idle", busy, 0);
    run_test(1, 0, 0);
    summary();
  end
endmodule